// File: doc/BRIEF.md
# Transmit Frame Buffer Controller

This block is the frame-aware transmit buffer between a DMA engine that writes outgoing frames and a MAC that pulls them one word at a time. Each stored word carries 32 data bits, a 2-bit count of valid bytes and an end-of-frame flag. By default the store is 4096 words (16 KB), which is enough for jumbo frames. A configuration input selects one of two rules for when the first word of a frame may leave. In threshold mode, enough data must be buffered. In whole-frame mode, the frame must be complete or the buffer must be nearly full. Once a frame has started, its words leave whenever the MAC asks for them and data is present.

The controller keeps the first part of the frame in flight until a speed-dependent number of bytes has gone out. If a half-duplex collision arrives inside that window, the frame is replayed from its first word. After the window closes, the space is returned to the writer and a collision no longer rewinds the frame. A one-cycle flush request empties the buffer. If the flush hits a frame in flight, the MAC receives an underflow pulse, which truncates the frame into a runt, and the DMA side receives a status word flagged as an underflow. Every frame that ends normally also produces a status word.

Top module: `tx_frame_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it, wr_ready is 1, and mac_valid and stat_valid are 0.
- R2: Words reach the MAC in the order they were written, with the 32-bit data, the 2-bit byte count (0 means 4 valid bytes, 1 to 3 mean that many) and the end-of-frame flag unchanged.
- R3: With cfg_store_fwd=0, the first word of a frame is granted only when the buffered words exceed 16*(cfg_thresh_sel+1), which is a threshold of 64, 128, 192 or 256 bytes for codes 0 to 3, or when at least one complete frame is stored.
- R4: With cfg_store_fwd=1, the first word of a frame is granted only when a complete frame is stored or when the occupancy is at least DEPTH-16 words.
- R5: A word is popped only on a cycle where mac_pop is 1, and it appears with mac_valid=1 on the next cycle. Inside a started frame, every mac_pop is granted while data is present.
- R6: wr_ready is 0 exactly when the occupancy, counted from the oldest word still held, equals the capacity. Writes offered while wr_ready is 0 are dropped.
- R7: With cfg_half_duplex=1, a collision inside the replay window, before the end-of-frame word has been popped, rewinds the read side. The next granted pop returns the frame's first word again.
- R8: The replay window lasts while no more than 24 words (96 bytes) have been sent with cfg_gig=0, or 137 words (548 bytes) with cfg_gig=1. Beyond it, the frame's space is freed at once (wr_ready can return) and a collision is ignored.
- R9: With cfg_half_duplex=0, collision has no effect.
- R10: A flush_req cycle empties the buffer on the next cycle. Stored words are discarded, and writes and pops in that cycle are ignored.
- R11: A flush while a frame is in flight gives stat_valid=1, stat_underflow=1 and mac_underflow=1 on the next cycle.
- R12: Popping an end-of-frame word gives stat_valid=1 with stat_underflow=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_store_fwd | input | 1 | 1 selects whole-frame release, 0 selects threshold release |
| cfg_thresh_sel | input | 2 | Threshold code: 64, 128, 192 or 256 bytes |
| cfg_gig | input | 1 | 1 selects the long (548-byte) replay window |
| cfg_half_duplex | input | 1 | 1 lets collision rewind a frame |
| flush_req | input | 1 | One-cycle request to empty the buffer |
| wr_valid | input | 1 | Write side offers a word |
| wr_data | input | 32 | Write data |
| wr_bcnt | input | 2 | Valid byte count of the word (0 means 4) |
| wr_eof | input | 1 | Word is the last of its frame |
| wr_ready | output | 1 | Buffer can accept a word this cycle |
| mac_pop | input | 1 | MAC requests the next word |
| collision | input | 1 | Half-duplex collision seen by the MAC |
| mac_valid | output | 1 | A popped word is presented |
| mac_data | output | 32 | Popped data |
| mac_bcnt | output | 2 | Popped byte count |
| mac_eof | output | 1 | Popped word ends its frame |
| mac_underflow | output | 1 | Frame in flight was cut by a flush |
| stat_valid | output | 1 | Per-frame status word is presented |
| stat_underflow | output | 1 | Status: the frame ended in underflow |

## Verification
Every result of this block is due exactly one edge after its cause. A granted pop shows up on mac_valid and the word fields at the next edge. A write or a released frame changes wr_ready at the next edge. An end-of-frame pop or a mid-frame flush raises stat_valid at the next edge. A reference model in the bench advances on each rising edge from the same inputs the design sees. The outputs are compared with its predictions at the following falling edge, so every check lands in the single cycle where the result is due. The directed runs cover both release modes at several threshold codes, replays inside and past both window lengths, a collision in full duplex, a full buffer that frees space partway through a frame, and a flush in the middle of a frame.

// File: rtl/tff_pkg.sv
package tff_pkg;

  typedef enum logic {
    REL_THRESHOLD = 1'b0,
    REL_WHOLE     = 1'b1
  } rel_mode_e;

endpackage

// File: rtl/tff_ram.sv
module tff_ram #(
  parameter int AW = 12,
  parameter int W  = 34
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;

  logic [W-1:0] mem [0:N-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tff_eof_flags.sv
module tff_eof_flags #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam int N = 1 << AW;

  logic [N-1:0] flags;

  always_ff @(posedge clk) begin
    if (we) flags[waddr] <= wbit;
  end

  // Read without a register so the grant logic sees the frame boundary in the pop cycle.
  assign rbit = flags[raddr];
endmodule

// File: rtl/tff_start_gate.sv
module tff_start_gate
  import tff_pkg::*;
#(
  parameter int PW         = 13,
  parameter int SEL_W      = 2,
  parameter int UNIT_WORDS = 16,
  parameter int DEPTH      = 4096,
  parameter int AF_MARGIN  = 16
) (
  input  rel_mode_e        mode,
  input  logic [SEL_W-1:0] thr_sel,
  input  logic [PW-1:0]    avail,
  input  logic [PW-1:0]    used,
  input  logic             frames_nz,
  output logic             start_ok
);
  localparam int NSEL = 1 << SEL_W;
  localparam logic [PW-1:0] AF_LEVEL = PW'(DEPTH - AF_MARGIN);

  logic [PW-1:0] thr_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_thr
    assign thr_tab[g] = PW'((g + 1) * UNIT_WORDS);
  end

  always_comb begin
    if (mode == REL_WHOLE) start_ok = frames_nz | (used >= AF_LEVEL);
    else                   start_ok = frames_nz | (avail > thr_tab[thr_sel]);
  end
endmodule

// File: rtl/tff_retry_window.sv
module tff_retry_window #(
  parameter int PW       = 13,
  parameter int LIM_SLOW = 24,
  parameter int LIM_FAST = 137
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          col,
  input  logic          pop,
  input  logic          start,
  input  logic          eof,
  input  logic          gig,
  input  logic [PW-1:0] rd_ptr,
  output logic          hold_q,
  output logic [PW-1:0] fs_q,
  output logic          hold_d,
  output logic [PW-1:0] fs_d
);
  localparam int SW = $clog2(LIM_FAST + 2);
  localparam logic [SW-1:0] SAT = SW'(LIM_FAST + 1);

  logic [SW-1:0] sent_q, sent_d, sent_n, lim;

  assign lim = gig ? SW'(LIM_FAST) : SW'(LIM_SLOW);
  assign sent_n = start ? SW'(1) : ((sent_q >= SAT) ? SAT : sent_q + 1'b1);

  always_comb begin
    hold_d = hold_q;
    fs_d   = fs_q;
    sent_d = sent_q;
    if (flush) begin
      hold_d = 1'b0;
      fs_d   = '0;
      sent_d = '0;
    end else if (col) begin
      hold_d = 1'b0;
      sent_d = '0;
    end else if (pop) begin
      sent_d = sent_n;
      if (start) fs_d = rd_ptr;
      hold_d = ~eof & (start | hold_q) & (sent_n <= lim);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      fs_q   <= '0;
      sent_q <= '0;
    end else begin
      hold_q <= hold_d;
      fs_q   <= fs_d;
      sent_q <= sent_d;
    end
  end
endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
  import tff_pkg::*;
#(
  parameter int DEPTH_WORDS      = 4096,
  parameter int DATA_W           = 32,
  parameter int BCNT_W           = 2,
  parameter int THR_SEL_W        = 2,
  parameter int THR_UNIT_BYTES   = 64,
  parameter int AF_MARGIN        = 16,
  parameter int RETRY_BYTES_SLOW = 96,
  parameter int RETRY_BYTES_GIG  = 548
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_store_fwd,
  input  logic [THR_SEL_W-1:0] cfg_thresh_sel,
  input  logic                 cfg_gig,
  input  logic                 cfg_half_duplex,
  input  logic                 flush_req,
  input  logic                 wr_valid,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [BCNT_W-1:0]    wr_bcnt,
  input  logic                 wr_eof,
  output logic                 wr_ready,
  input  logic                 mac_pop,
  input  logic                 collision,
  output logic                 mac_valid,
  output logic [DATA_W-1:0]    mac_data,
  output logic [BCNT_W-1:0]    mac_bcnt,
  output logic                 mac_eof,
  output logic                 mac_underflow,
  output logic                 stat_valid,
  output logic                 stat_underflow
);
  localparam int AW         = $clog2(DEPTH_WORDS);
  localparam int PW         = AW + 1;
  localparam int BPW        = DATA_W / 8;
  localparam int UNIT_WORDS = THR_UNIT_BYTES / BPW;
  localparam int LIM_SLOW   = RETRY_BYTES_SLOW / BPW;
  localparam int LIM_FAST   = RETRY_BYTES_GIG / BPW;
  localparam int RW         = DATA_W + BCNT_W;

  logic [PW-1:0] wr_ptr_q, rd_ptr_q, frames_q;
  logic [PW-1:0] wr_ptr_d, rd_ptr_d, frames_d;
  logic [PW-1:0] avail, used, rel_ptr, used_d;
  logic          in_frame_q, in_frame_d;
  logic          wr_ready_q;
  logic          hold_q, hold_d;
  logic [PW-1:0] fs_q, fs_d;
  logic          start_ok, col, pop, wr_acc, eof_rd, cut;
  logic [RW-1:0] ram_q;
  rel_mode_e     mode;

  assign mode    = cfg_store_fwd ? REL_WHOLE : REL_THRESHOLD;
  assign avail   = wr_ptr_q - rd_ptr_q;
  assign rel_ptr = hold_q ? fs_q : rd_ptr_q;
  assign used    = wr_ptr_q - rel_ptr;

  assign col    = collision & cfg_half_duplex & in_frame_q & hold_q & ~flush_req;
  assign pop    = mac_pop & ~flush_req & ~col & (avail != '0) & (in_frame_q | start_ok);
  assign wr_acc = wr_valid & wr_ready_q & ~flush_req;
  assign cut    = flush_req & in_frame_q;

  tff_start_gate #(
    .PW(PW), .SEL_W(THR_SEL_W), .UNIT_WORDS(UNIT_WORDS),
    .DEPTH(DEPTH_WORDS), .AF_MARGIN(AF_MARGIN)
  ) u_gate (
    .mode(mode), .thr_sel(cfg_thresh_sel), .avail(avail), .used(used),
    .frames_nz(frames_q != '0), .start_ok(start_ok)
  );

  tff_ram #(.AW(AW), .W(RW)) u_ram (
    .clk(clk), .we(wr_acc), .waddr(wr_ptr_q[AW-1:0]), .wdata({wr_data, wr_bcnt}),
    .re(pop), .raddr(rd_ptr_q[AW-1:0]), .rdata(ram_q)
  );

  tff_eof_flags #(.AW(AW)) u_flags (
    .clk(clk), .we(wr_acc), .waddr(wr_ptr_q[AW-1:0]), .wbit(wr_eof),
    .raddr(rd_ptr_q[AW-1:0]), .rbit(eof_rd)
  );

  tff_retry_window #(.PW(PW), .LIM_SLOW(LIM_SLOW), .LIM_FAST(LIM_FAST)) u_retry (
    .clk(clk), .rst(rst), .flush(flush_req), .col(col), .pop(pop),
    .start(~in_frame_q), .eof(eof_rd), .gig(cfg_gig), .rd_ptr(rd_ptr_q),
    .hold_q(hold_q), .fs_q(fs_q), .hold_d(hold_d), .fs_d(fs_d)
  );

  always_comb begin
    if (flush_req) begin
      wr_ptr_d   = '0;
      rd_ptr_d   = '0;
      frames_d   = '0;
      in_frame_d = 1'b0;
    end else begin
      wr_ptr_d   = wr_ptr_q + PW'(wr_acc);
      frames_d   = frames_q + PW'(wr_acc & wr_eof) - PW'(pop & eof_rd);
      if (col) begin
        rd_ptr_d   = fs_q;
        in_frame_d = 1'b0;
      end else if (pop) begin
        rd_ptr_d   = rd_ptr_q + 1'b1;
        in_frame_d = ~eof_rd;
      end else begin
        rd_ptr_d   = rd_ptr_q;
        in_frame_d = in_frame_q;
      end
    end
    used_d = wr_ptr_d - (hold_d ? fs_d : rd_ptr_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q       <= '0;
      rd_ptr_q       <= '0;
      frames_q       <= '0;
      in_frame_q     <= 1'b0;
      wr_ready_q     <= 1'b1;
      mac_valid      <= 1'b0;
      mac_eof        <= 1'b0;
      mac_underflow  <= 1'b0;
      stat_valid     <= 1'b0;
      stat_underflow <= 1'b0;
    end else begin
      wr_ptr_q       <= wr_ptr_d;
      rd_ptr_q       <= rd_ptr_d;
      frames_q       <= frames_d;
      in_frame_q     <= in_frame_d;
      wr_ready_q     <= ~used_d[PW-1];
      mac_valid      <= pop;
      if (pop) mac_eof <= eof_rd;
      mac_underflow  <= cut;
      stat_valid     <= (pop & eof_rd) | cut;
      stat_underflow <= cut;
    end
  end

  assign wr_ready = wr_ready_q;
  assign mac_data = ram_q[RW-1:BCNT_W];
  assign mac_bcnt = ram_q[BCNT_W-1:0];
endmodule

// File: rtl/tx_frame_fifo_chk.sv
module tx_frame_fifo_chk #(
  parameter int PW         = 13,
  parameter int SEL_W      = 2,
  parameter int DEPTH      = 4096,
  parameter int UNIT_WORDS = 16,
  parameter int AF_MARGIN  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_store_fwd,
  input logic [SEL_W-1:0] cfg_thresh_sel,
  input logic             cfg_half_duplex,
  input logic             flush_req,
  input logic             mac_pop,
  input logic             mac_valid,
  input logic             mac_eof,
  input logic             mac_underflow,
  input logic             stat_valid,
  input logic             stat_underflow,
  input logic             wr_ready,
  input logic             in_frame,
  input logic [PW-1:0]    frames,
  input logic [PW-1:0]    avail,
  input logic [PW-1:0]    used,
  input logic [PW-1:0]    rd_ptr
);
  logic [PW-1:0] thr_now, rd_prev, rd_delta;

  assign thr_now  = PW'((int'(cfg_thresh_sel) + 1) * UNIT_WORDS);
  assign rd_delta = rd_ptr - rd_prev;

  always_ff @(posedge clk) rd_prev <= rd_ptr;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_ready && !mac_valid && !stat_valid));

  p_thresh_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (mac_pop && !in_frame && !cfg_store_fwd && !flush_req && frames == '0 && avail <= thr_now)
    |=> !mac_valid);

  p_frame_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (mac_pop && !in_frame && cfg_store_fwd && !flush_req && frames == '0 &&
     used < PW'(DEPTH - AF_MARGIN)) |=> !mac_valid);

  p_pop_on_request_r5: assert property (@(posedge clk) disable iff (rst)
    mac_valid |-> $past(mac_pop));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    used <= PW'(DEPTH));

  p_no_rewind_full_duplex_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_half_duplex && !flush_req) |=> (rd_delta <= PW'(1)));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> (avail == '0 && !mac_valid));

  p_flush_underflow_r11: assert property (@(posedge clk) disable iff (rst)
    (flush_req && in_frame) |=> (stat_valid && stat_underflow && mac_underflow));

  p_eof_status_r12: assert property (@(posedge clk) disable iff (rst)
    (mac_valid && mac_eof) |-> (stat_valid && !stat_underflow));
endmodule

bind tx_frame_fifo tx_frame_fifo_chk #(
  .PW(PW), .SEL_W(THR_SEL_W), .DEPTH(DEPTH_WORDS),
  .UNIT_WORDS(UNIT_WORDS), .AF_MARGIN(AF_MARGIN)
) u_chk (
  .clk(clk), .rst(rst), .cfg_store_fwd(cfg_store_fwd), .cfg_thresh_sel(cfg_thresh_sel),
  .cfg_half_duplex(cfg_half_duplex), .flush_req(flush_req), .mac_pop(mac_pop),
  .mac_valid(mac_valid), .mac_eof(mac_eof), .mac_underflow(mac_underflow),
  .stat_valid(stat_valid), .stat_underflow(stat_underflow), .wr_ready(wr_ready),
  .in_frame(in_frame_q), .frames(frames_q), .avail(avail), .used(used), .rd_ptr(rd_ptr_q)
);

// File: tb/test_tx_frame_fifo.sv
module test_tx_frame_fifo;
  localparam int DEPTH    = 4096;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_store_fwd = 1'b0, cfg_gig = 1'b0, cfg_half_duplex = 1'b0;
  logic [1:0]  cfg_thresh_sel = 2'd0;
  logic        flush_req = 1'b0, wr_valid = 1'b0, wr_eof = 1'b0, mac_pop = 1'b0, collision = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_bcnt = '0;
  logic        wr_ready, mac_valid, mac_eof, mac_underflow, stat_valid, stat_underflow;
  logic [31:0] mac_data;
  logic [1:0]  mac_bcnt;

  always #2 clk = ~clk;

  tx_frame_fifo i_tx_frame_fifo (
    .clk(clk), .rst(rst), .cfg_store_fwd(cfg_store_fwd), .cfg_thresh_sel(cfg_thresh_sel),
    .cfg_gig(cfg_gig), .cfg_half_duplex(cfg_half_duplex), .flush_req(flush_req),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_bcnt(wr_bcnt), .wr_eof(wr_eof),
    .wr_ready(wr_ready), .mac_pop(mac_pop), .collision(collision), .mac_valid(mac_valid),
    .mac_data(mac_data), .mac_bcnt(mac_bcnt), .mac_eof(mac_eof),
    .mac_underflow(mac_underflow), .stat_valid(stat_valid), .stat_underflow(stat_underflow)
  );

  int    checks = 0, fails = 0, cyc = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;
  logic [31:0] seq = 32'h1000;

  // Reference model state
  int  m_wc, m_rc, m_fs, m_sent, m_frames;
  bit  m_inf, m_hold;
  bit  e_ready = 1'b1, e_valid, e_st, e_suf, e_muf;
  logic [34:0] e_word;
  logic [34:0] mmem [DEPTH];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : ref_model
    int avail, used, rel, lim, thr;
    bit col, pop, wr, sok;
    logic [34:0] w;
    if (rst) begin
      m_wc = 0; m_rc = 0; m_fs = 0; m_sent = 0; m_frames = 0; m_inf = 0; m_hold = 0;
      e_ready = 1; e_valid = 0; e_st = 0; e_suf = 0; e_muf = 0;
    end else if (flush_req) begin
      e_st = m_inf; e_suf = m_inf; e_muf = m_inf; e_valid = 0;
      m_wc = 0; m_rc = 0; m_fs = 0; m_sent = 0; m_frames = 0; m_inf = 0; m_hold = 0;
      e_ready = 1;
    end else begin
      e_st = 0; e_suf = 0; e_muf = 0; e_valid = 0;
      rel   = m_hold ? m_fs : m_rc;
      avail = m_wc - m_rc;
      used  = m_wc - rel;
      thr   = 16 * (int'(cfg_thresh_sel) + 1);
      sok   = (m_frames > 0) || (cfg_store_fwd ? (used >= DEPTH - 16) : (avail > thr));
      col   = collision && cfg_half_duplex && m_inf && m_hold;
      pop   = mac_pop && !col && (avail > 0) && (m_inf || sok);
      wr    = wr_valid && e_ready;
      lim   = cfg_gig ? 137 : 24;
      if (pop) begin
        w = mmem[m_rc % DEPTH];
        if (!m_inf) begin m_fs = m_rc; m_sent = 1; m_hold = 1; m_inf = 1; end
        else m_sent++;
        if (m_sent > lim) m_hold = 0;
        if (w[0]) begin m_inf = 0; m_hold = 0; m_frames--; e_st = 1; end
        m_rc++;
        e_valid = 1;
        e_word  = w;
      end
      if (col) begin m_rc = m_fs; m_inf = 0; m_hold = 0; m_sent = 0; end
      if (wr) begin
        mmem[m_wc % DEPTH] = {wr_data, wr_bcnt, wr_eof};
        m_wc++;
        if (wr_eof) m_frames++;
      end
      rel = m_hold ? m_fs : m_rc;
      e_ready = (m_wc - rel) < DEPTH;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(wr_ready == e_ready, "wr_ready", wr_ready, e_ready);
      chk(mac_valid == e_valid, "mac_valid", mac_valid, e_valid);
      if (e_valid)
        chk({mac_data, mac_bcnt, mac_eof} == e_word, "mac_word",
            {mac_data, mac_bcnt, mac_eof}, e_word);
      chk(stat_valid == e_st, "stat_valid", stat_valid, e_st);
      if (e_st) chk(stat_underflow == e_suf, "stat_underflow", stat_underflow, e_suf);
      chk(mac_underflow == e_muf, "mac_underflow", mac_underflow, e_muf);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      checks++;
      $display("FAIL watchdog %s actual=%0d expected<=%0d", phase, cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input bit wv, input bit we, input logic [1:0] bc, input bit pp, input bit cl);
    wr_valid = wv; wr_eof = we; wr_bcnt = bc; wr_data = seq; seq = seq + 1;
    mac_pop = pp; collision = cl; flush_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic put_frame(input int n, input logic [1:0] bc, input bit pp);
    for (int i = 0; i < n; i++) step(1'b1, i == n - 1, (i == n - 1) ? bc : 2'd0, pp, 1'b0);
  endtask

  task automatic pops(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic hit_collision();
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic do_flush();
    wr_valid = 1'b1; wr_eof = 1'b0; mac_pop = 1'b1; collision = 1'b0; flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0; wr_valid = 1'b0; mac_pop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    chk(mac_valid == 1'b0, "R1 mac_valid", mac_valid, 0);
    chk(stat_valid == 1'b0, "R1 stat_valid", stat_valid, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);

    // R3: threshold release, codes 0 and 3
    phase = "R3";
    cfg_thresh_sel = 2'd0;
    for (int i = 0; i < 40; i++) step(1'b1, i == 39, (i == 39) ? 2'd3 : 2'd0, 1'b1, 1'b0);
    pops(60);
    cfg_thresh_sel = 2'd3;
    for (int i = 0; i < 80; i++) step(1'b1, i == 79, (i == 79) ? 2'd1 : 2'd0, 1'b1, 1'b0);
    pops(90);
    cfg_thresh_sel = 2'd1;

    // R2: short frames with every byte-count code
    phase = "R2";
    put_frame(1, 2'd0, 1'b0);
    put_frame(2, 2'd1, 1'b0);
    put_frame(3, 2'd2, 1'b0);
    put_frame(5, 2'd3, 1'b0);
    pops(20);

    // R12: end-of-frame status for single and back-to-back frames
    phase = "R12";
    put_frame(4, 2'd1, 1'b1);
    put_frame(1, 2'd2, 1'b1);
    pops(10);

    // R5: intermittent requests inside a frame
    phase = "R5";
    put_frame(8, 2'd2, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 2'd0, i % 3 != 0, 1'b0);

    // R4: whole-frame release waits for the end-of-frame word
    phase = "R4";
    cfg_store_fwd = 1'b1;
    for (int i = 0; i < 30; i++) step(1'b1, i == 29, (i == 29) ? 2'd0 : 2'd0, 1'b1, 1'b0);
    pops(40);
    cfg_store_fwd = 1'b0;
    cfg_thresh_sel = 2'd0;

    // R7: replay inside the short window
    phase = "R7";
    cfg_half_duplex = 1'b1;
    put_frame(60, 2'd3, 1'b0);
    pops(10);
    hit_collision();
    pops(70);

    // R8: window length at both speeds
    phase = "R8";
    put_frame(200, 2'd1, 1'b0);
    pops(30);
    hit_collision();
    pops(200);
    cfg_gig = 1'b1;
    put_frame(200, 2'd2, 1'b0);
    pops(100);
    hit_collision();
    pops(140);
    hit_collision();
    pops(220);
    cfg_gig = 1'b0;

    // R9: full duplex ignores collision
    phase = "R9";
    cfg_half_duplex = 1'b0;
    put_frame(50, 2'd0, 1'b0);
    pops(5);
    hit_collision();
    pops(60);

    // R6: fill to capacity, writes beyond it dropped
    phase = "R6";
    cfg_store_fwd = 1'b1;
    for (int i = 0; i < DEPTH + 4; i++) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    // R8: space returns once the short window has passed
    phase = "R8";
    pops(30);

    // R11: flush in the middle of a frame
    phase = "R11";
    do_flush();
    @(negedge clk);

    // R10: buffer is empty afterwards, old data gone
    phase = "R10";
    cfg_store_fwd = 1'b0;
    pops(5);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    do_flush();
    put_frame(5, 2'd3, 1'b0);
    pops(10);
    do_flush();
    pops(4);

    cmp_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule